// File: doc/BRIEF.md
# Infrared Serial Pulse Codec

This block sits between a UART serial engine and an infrared transceiver. In the send direction it watches the UART transmit line once per bit period. Each low bit becomes a single short high pulse on the IR output. Each high bit leaves the IR output dark. In the receive direction it turns every pulse it sees on the IR input back into a low level on the UART-side receive line. That low level lasts to the end of the bit window in which the pulse arrived.

Bit timing comes from a sampling tick that fires sixteen times per bit. The block counts these ticks into a 16-step phase. The tick with phase 0 opens a bit, and the tick with phase 15 closes it. The phase restarts at 0 whenever the block is enabled. A 3-bit select picks the transmit pulse width. It can be three sixteenths of a bit, or a fixed count of system clocks. A fixed width stays the same when the bit rate changes. Software must pick a select value that meets the minimum pulse width of the link at the chosen clock frequency.

Top module: `irsir_codec`

## Requirements
- R1: When enabled, a `bit_tick` at phase 0 with `uart_txd` low starts a high pulse on `ir_txd` on the next clock edge.
- R2: A `bit_tick` at phase 0 with `uart_txd` high starts no pulse, so `ir_txd` stays low for that bit.
- R3: With `width_sel` = 0, the pulse lasts exactly 3 tick intervals (3/16 of a bit). It falls on the clock edge that samples the third tick after the start tick.
- R4: With `width_sel` = s in 1..7, the pulse lasts exactly 2^(s+2) system clocks (s=1: 8, s=2: 16, s=3: 32, s=4: 64).
- R5: While `en` is low, `ir_txd` is low one clock later and no pulse starts. The tick phase is held at 0, so the first tick after enabling opens a bit.
- R6: A rising edge on `ir_rxd` drives `uart_rxd` low 3 clocks later, through two synchroniser stages and an edge register. `uart_rxd` stays low until the tick at phase 15 ends that bit window, and it is high again on the following clock.
- R7: A high pulse on `ir_rxd` of a single system clock is still decoded as a 0 bit, as in R6.
- R8: A bit window in which `ir_rxd` stays low leaves `uart_rxd` high for the whole window.
- R9: While `en` is low, `uart_rxd` is held high (idle) and pulses on `ir_rxd` are ignored.
- R10: During and after reset, `ir_txd` is low and `uart_rxd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Block enable |
| bit_tick | input | 1 | One-clock sampling strobe, 16 per bit |
| width_sel | input | 3 | Transmit pulse width select (0 = 3/16 bit, else 2^(sel+2) clocks) |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_rxd | input | 1 | Raw IR receiver input (asynchronous) |
| ir_txd | output | 1 | IR transmitter drive, high = light |
| uart_rxd | output | 1 | Reconstructed serial data to the UART receiver |

## Verification
A wrong tick phase shows at the ports within one bit. Transmit pulses start on the wrong tick, and receive lows are released on the wrong tick. An off-by-one in the pulse counters changes each measured pulse width by a whole clock or a whole tick. The scoreboard catches this on the first zero bit. A stuck receive hold or a missed edge shows as a `uart_rxd` level that is wrong inside the same bit window. A leak in the enable gating shows as an unexpected pulse or low within the next bit.

// File: rtl/irsir_pkg.sv
// Package: shared constants for the infrared pulse codec.
// Assumes 16 sampling ticks per bit and a 3-bit width select.
package irsir_pkg;
    localparam int TICKS_PER_BIT = 16;
    localparam int PHASE_W       = $clog2(TICKS_PER_BIT);
    localparam int FRAC_TICKS    = 3;
    localparam int SEL_W         = 3;
    localparam int SYNC_STAGES   = 2;

    typedef enum logic {
        WIDTH_FRACTIONAL = 1'b0,
        WIDTH_FIXED      = 1'b1
    } width_mode_e;
endpackage

// File: rtl/irsir_bit_phase.sv
// Module: irsir_bit_phase
// Counts sampling ticks into a bit phase. It gives a strobe when a bit opens
// (tick at phase 0) and one when a bit closes (tick at the last phase).
// Assumes bit_tick is a one-clock strobe. The phase is held at 0 while disabled.
module irsir_bit_phase #(
    parameter int TICKS   = 16,
    localparam int PW     = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_tick,
    output logic bit_open,
    output logic bit_close
);
    localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

    logic [PW-1:0] phase_q;

    // Advance the phase on each tick, wrapping at the bit length.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= '0;
        end else if (bit_tick) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign bit_open  = en && bit_tick && (phase_q == '0);
    assign bit_close = en && bit_tick && (phase_q == LAST);

    // R5: a disabled block restarts at phase 0
    assert_phase_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase_q == '0));
endmodule

// File: rtl/irsir_tx_shaper.sv
// Module: irsir_tx_shaper
// Turns each low UART bit into one high IR pulse that starts one clock after the
// bit opens. The width is either a number of sampling ticks or a power-of-two
// number of system clocks. Assumes width_sel is stable while a pulse is out.
module irsir_tx_shaper
    import irsir_pkg::*;
#(
    parameter int SW        = SEL_W,
    parameter int FTICKS    = FRAC_TICKS,
    localparam int CNT_W    = (1 << SW) + 1,
    localparam int TC_W     = (FTICKS > 1) ? $clog2(FTICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_tick,
    input  logic          bit_open,
    input  logic [SW-1:0] width_sel,
    input  logic          uart_txd,
    output logic          ir_txd
);
    localparam logic [CNT_W-1:0] ALL_ONES  = '1;
    localparam logic [TC_W-1:0]  TICK_LAST = TC_W'(FTICKS - 1);

    width_mode_e      mode;
    logic [CNT_W-1:0] clk_last;
    logic             pulse_on_q;
    logic [CNT_W-1:0] clk_cnt_q;
    logic [TC_W-1:0]  tick_cnt_q;
    logic             start;
    logic             pulse_done;

    // Decode the select into a width mode and the last clock count of a fixed pulse.
    always_comb begin
        mode     = (width_sel == '0) ? WIDTH_FRACTIONAL : WIDTH_FIXED;
        clk_last = ALL_ONES >> (CNT_W - 2 - int'(width_sel));
    end

    assign start = bit_open && !uart_txd;

    // Flag the last cycle of the pulse in either width mode.
    always_comb begin
        if (mode == WIDTH_FRACTIONAL) begin
            pulse_done = bit_tick && (tick_cnt_q == TICK_LAST);
        end else begin
            pulse_done = (clk_cnt_q == clk_last);
        end
    end

    // Pulse state: a new start wins, disable clears, otherwise count to the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_on_q <= 1'b0;
            clk_cnt_q  <= '0;
            tick_cnt_q <= '0;
        end else if (start) begin
            pulse_on_q <= 1'b1;
            clk_cnt_q  <= '0;
            tick_cnt_q <= '0;
        end else if (!en) begin
            pulse_on_q <= 1'b0;
            clk_cnt_q  <= '0;
            tick_cnt_q <= '0;
        end else if (pulse_on_q) begin
            if (pulse_done) begin
                pulse_on_q <= 1'b0;
            end
            clk_cnt_q <= clk_cnt_q + 1'b1;
            if (bit_tick) begin
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
        end
    end

    assign ir_txd = pulse_on_q;

    // R1: a low bit at bit open lights the output on the next edge
    assert_zero_lights_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_open && !uart_txd) |=> (ir_txd && clk_cnt_q == '0));
    // R2: a high bit at bit open never starts a pulse from a dark output
    assert_one_stays_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_open && uart_txd && !ir_txd) |=> !ir_txd);
    // R4: a fixed pulse never runs past its selected clock count
    assert_fixed_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_txd && mode == WIDTH_FIXED && $stable(width_sel)) |-> (clk_cnt_q <= clk_last));
    // R5: disabling darkens the output on the next edge
    assert_dark_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ir_txd);
endmodule

// File: rtl/irsir_rx_decoder.sv
// Module: irsir_rx_decoder
// Synchronises the raw IR input, finds its rising edges, and holds the UART-side
// line low from a detected edge to the end of the current bit window. Assumes
// that a pulse of any width, even one clock, means a 0 bit.
module irsir_rx_decoder
    import irsir_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_close,
    input  logic ir_rxd,
    output logic uart_rxd
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic              hold_low_q;

    // Synchroniser chain: first stage takes the raw pin, later stages take their neighbour.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    sync_q[g] <= rst_n ? ir_rxd : 1'b0;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    sync_q[g] <= rst_n ? sync_q[g-1] : 1'b0;
                end
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        prev_q <= rst_n ? sync_q[STAGES-1] : 1'b0;
    end

    assign rise = sync_q[STAGES-1] && !prev_q;

    // Hold the line low from an edge until the bit window closes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold_low_q <= 1'b0;
        end else if (rise) begin
            hold_low_q <= 1'b1;
        end else if (bit_close) begin
            hold_low_q <= 1'b0;
        end
    end

    assign uart_rxd = !hold_low_q;

    // R6: a detected edge pulls the line low on the next edge
    assert_edge_pulls_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rise) |=> !uart_rxd);
    // R6: a low line returns high only at a window close
    assert_release_at_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !uart_rxd && !bit_close && !rise) |=> !uart_rxd);
    // R9: disabled means idle high
    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> uart_rxd);
endmodule

// File: rtl/irsir_codec.sv
// Module: irsir_codec (top)
// Infrared pulse codec between a UART and an IR transceiver. It ties a shared
// bit-phase counter to the transmit shaper and the receive decoder.
// Assumes bit_tick fires 16 times per bit and en is a synchronous level.
module irsir_codec
    import irsir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_tick,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             uart_txd,
    input  logic             ir_rxd,
    output logic             ir_txd,
    output logic             uart_rxd
);
    logic bit_open;
    logic bit_close;

    irsir_bit_phase #(.TICKS(TICKS_PER_BIT)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_tick  (bit_tick),
        .bit_open  (bit_open),
        .bit_close (bit_close)
    );

    irsir_tx_shaper #(.SW(SEL_W), .FTICKS(FRAC_TICKS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_tick  (bit_tick),
        .bit_open  (bit_open),
        .width_sel (width_sel),
        .uart_txd  (uart_txd),
        .ir_txd    (ir_txd)
    );

    irsir_rx_decoder #(.STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_close (bit_close),
        .ir_rxd    (ir_rxd),
        .uart_rxd  (uart_rxd)
    );

    // R10: the output pins are quiet in the cycle after a reset edge
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!ir_txd && uart_rxd));
endmodule

// File: tb/irsir_codec_test.sv
// Bench for irsir_codec. A driver pushes expected transmit pulse widths into a
// queue. A monitor measures each pulse on ir_txd and compares it with the queue.
// Receive behaviour is checked inline at fixed offsets in the bit.
module irsir_codec_test;
    localparam int DIV = 4;  // clocks per sampling tick; one bit = 64 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bit_tick = 1'b0;
    logic [2:0] width_sel = 3'd0;
    logic       uart_txd = 1'b1;
    logic       ir_rxd = 1'b0;
    logic       ir_txd;
    logic       uart_rxd;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int run_len = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irsir_codec uut (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick),
        .width_sel(width_sel), .uart_txd(uart_txd), .ir_rxd(ir_rxd),
        .ir_txd(ir_txd), .uart_rxd(uart_rxd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measure each high run on ir_txd and compare with the scoreboard.
    always @(negedge clk) begin
        if (ir_txd) begin
            run_len++;
        end else if (run_len > 0) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected pulse", run_len, 0);
            end else begin
                check("R1/R3/R4 pulse width", run_len, exp_q.pop_front());
            end
            run_len = 0;
        end
    end

    // Produce the 16 ticks of one bit, DIV clocks apart.
    task automatic tick_bit();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
            repeat (DIV - 2) @(negedge clk);
        end
    endtask

    // Driver: send one UART bit and queue the pulse width it should produce.
    task automatic send_bit(input bit b);
        uart_txd = b;
        if (!b && en) begin
            if (width_sel == 3'd0) exp_q.push_back(3 * DIV);
            else exp_q.push_back(1 << (width_sel + 2));
        end
        tick_bit();
        uart_txd = 1'b1;
    endtask

    // Receive one bit window; pulse_len 0 means no pulse.
    task automatic rx_bit(input int pulse_len, input int exp_low, input string req);
        fork
            tick_bit();
            begin
                repeat (6) @(negedge clk);
                if (pulse_len > 0) begin
                    ir_rxd = 1'b1;
                    repeat (pulse_len) @(negedge clk);
                    ir_rxd = 1'b0;
                end
                repeat (20) @(negedge clk);
                check(req, uart_rxd, exp_low ? 0 : 1);
            end
        join
        @(negedge clk);
        check({req, " released at window end"}, uart_rxd, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 ir_txd in reset", ir_txd, 0);
        check("R10 uart_rxd in reset", uart_rxd, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ir_txd after reset", ir_txd, 0);
        en = 1'b1;
        @(negedge clk);

        // R1, R2, R3: fractional width over a mixed pattern
        width_sel = 3'd0;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);

        // R4: fixed widths, each zero followed by a one
        for (int s = 1; s <= 4; s++) begin
            width_sel = 3'(s);
            send_bit(1'b0);
            send_bit(1'b1);
        end
        width_sel = 3'd0;

        // R2: a run of ones gives no pulse at all
        send_bit(1'b1);
        check("R2 dark after ones", ir_txd, 0);

        // R5: disabled transmitter stays dark
        en = 1'b0;
        @(negedge clk);
        send_bit(1'b0);
        check("R5 dark while disabled", ir_txd, 0);

        // R9: disabled receiver ignores pulses
        rx_bit(3, 0, "R9 idle while disabled");
        en = 1'b1;
        @(negedge clk);

        // R5: re-enable realigns the phase, first tick opens a bit
        send_bit(1'b0);

        // R6, R7, R8: receive decoding
        rx_bit(4, 1, "R6 pulse held low");
        rx_bit(0, 0, "R8 no pulse stays high");
        rx_bit(1, 1, "R7 one-clock pulse decodes zero");

        // R6: check the low appears 3 clocks after the rising edge
        fork
            tick_bit();
            begin
                repeat (6) @(negedge clk);
                ir_rxd = 1'b1;
                repeat (2) @(negedge clk);
                check("R6 not yet low", uart_rxd, 1);
                @(negedge clk);
                check("R6 low after three clocks", uart_rxd, 0);
                ir_rxd = 1'b0;
            end
        join
        @(negedge clk);
        check("R6 high after window", uart_rxd, 1);

        repeat (10) @(negedge clk);
        check("R1 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule